// File: doc/BRIEF.md
# Bus Target Transaction Controller

This block is the responding side of a parallel bus that carries address and data on the same wires. It watches the frame and initiator-ready strobes, the command nibble on the command/byte-enable lines and a hit flag from an external address decoder. When a transaction is addressed to it, the block claims the transaction. It paces each data phase with the target-ready strobe, asks for a retry or a disconnect through the stop strobe, and turns the address/data and parity drivers on and off at the right clocks. All handshake strobes are active low.

A single twelve-state machine covers every transaction type. These are unclaimed transactions, burst memory reads and writes, single-phase I/O and configuration accesses, retry, and the backoff clock that follows a retry or a disconnect. For every completed data phase the block gives a one-clock strobe naming the kind of access. The storage behind the block uses these strobes. The backing logic also supplies two inputs. A ready input inserts wait states. A retry input, sampled with the address, makes the target refuse the transaction.

Top module: `target_ctrl`

## Requirements
- R1: While reset is held and on the first clock after it is released, devselN, trdyN and stopN are high and adOe, parOe and every access strobe are 0.
- R2: Command decode on cbe at the address clock: 0110, 1100 and 1110 are memory reads; 0111 and 1111 are memory writes; 0010 is an I/O read; 0011 is an I/O write; 1010 is a configuration read; 1011 is a configuration write. Configuration commands are claimed only when cfgSel is high, and the others only when addrHit is high. Any other code, 0000 included, is never claimed, and an unclaimed transaction leaves devselN, trdyN and stopN high until the bus has gone idle.
- R3: On a claimed read with no retry, the clock after the address is a turnaround clock. In it devselN is low, trdyN is high and adOe is 0. From the next clock on, adOe is 1 for every data phase.
- R4: On a claimed write with no retry, devselN is low on the clock right after the address, and that clock is already a data phase (no turnaround).
- R5: In a data phase trdyN is low exactly when userReady is high. A transfer happens only on a clock where irdyN and trdyN are both low. On each transfer, exactly one strobe pulses for one clock, and that strobe matches the command latched at the address clock. cbe and addrHit during data phases have no effect.
- R6: Memory commands run as bursts: transfers continue until one happens with frameN high. On the following clock devselN, trdyN, stopN and adOe are released.
- R7: I/O and configuration accesses are single-phase: stopN is low in their data phase. If frameN is still low when the transfer happens, the target keeps devselN and stopN low with trdyN high until frameN is seen high, then releases everything on the next clock.
- R8: If userRetry is high at a claimed address clock, then on the next clock devselN and stopN go low with trdyN high, and no strobe pulses. This lasts until frameN is seen high. On the following clock the target backs off with all three strobes high.
- R9: parOe equals the value adOe had on the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Transaction frame from the initiator, active low |
| irdyN | input | 1 | Initiator ready, active low |
| cbe | input | 4 | Command at the address clock, byte enables afterwards |
| addrHit | input | 1 | Address decoder hit for memory and I/O commands |
| cfgSel | input | 1 | Select for configuration commands |
| userReady | input | 1 | Backing logic can transfer data this clock |
| userRetry | input | 1 | Backing logic refuses the transaction now (sampled with the address) |
| devselN | output | 1 | Device select, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Stop request, active low |
| adOe | output | 1 | Drive enable for the address/data lines |
| parOe | output | 1 | Drive enable for the parity line |
| memRdStb | output | 1 | Memory read transfer strobe |
| memWrStb | output | 1 | Memory write transfer strobe |
| ioRdStb | output | 1 | I/O read transfer strobe |
| ioWrStb | output | 1 | I/O write transfer strobe |
| cfgRdStb | output | 1 | Configuration read transfer strobe |
| cfgWrStb | output | 1 | Configuration write transfer strobe |

## Verification
The bench plays the initiator and randomizes several things: target and initiator wait states, burst lengths, hit and select flags, and the byte-enable and hit values during data phases. Any strobe that follows the live cbe instead of the latched command then fires the wrong kind of access. The no-op code 0000 with a hit, and a configuration write without select, check that the decoder claims only what it should; a decoder that claims them would drive devselN. Single I/O writes with several phases requested check the disconnect. A controller that kept transferring would pulse a second strobe, and one that dropped stopN early would end the handshake before frameN rises. Retries on reads and writes check for the missing turnaround or the stray strobe a wrong retry path would give. Every read end checks that parOe trails adOe by exactly one clock.

// File: rtl/target_ctrl_pkg.sv
package target_ctrl_pkg;

  localparam int CMD_W   = 4;
  localparam int NUM_CLS = 6;

  // Access kinds; value i+1 maps to strobe bit i.
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_MEM_RD = 3'd1,
    CLS_MEM_WR = 3'd2,
    CLS_IO_RD  = 3'd3,
    CLS_IO_WR  = 3'd4,
    CLS_CFG_RD = 3'd5,
    CLS_CFG_WR = 3'd6
  } cmd_class_e;

  // Control to datapath strobes.
  typedef struct packed {
    logic latchCmd;
    logic xfer;
    logic driveAd;
  } ctl_strobe_t;

  function automatic cmd_class_e decodeCmd(input logic [CMD_W-1:0] code);
    case (code)
      4'b0110, 4'b1100, 4'b1110: decodeCmd = CLS_MEM_RD;
      4'b0111, 4'b1111:          decodeCmd = CLS_MEM_WR;
      4'b0010:                   decodeCmd = CLS_IO_RD;
      4'b0011:                   decodeCmd = CLS_IO_WR;
      4'b1010:                   decodeCmd = CLS_CFG_RD;
      4'b1011:                   decodeCmd = CLS_CFG_WR;
      default:                   decodeCmd = CLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/target_ctrl_dp.sv
module target_ctrl_dp
  import target_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CMD_W-1:0]    cbe,
  input  ctl_strobe_t         ctl,
  output cmd_class_e          liveClass,
  output cmd_class_e          heldClass,
  output logic                adOe,
  output logic                parOe,
  output logic [NUM_CLS-1:0]  accessStb
);

  assign liveClass = decodeCmd(cbe);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldClass <= CLS_NONE;
      parOe     <= 1'b0;
    end else begin
      if (ctl.latchCmd) heldClass <= liveClass;
      parOe <= ctl.driveAd;
    end
  end

  assign adOe = ctl.driveAd;

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_stb
    assign accessStb[i] = ctl.xfer && (heldClass == cmd_class_e'(i + 1));
  end

endmodule

// File: rtl/target_ctrl_fsm.sv
module target_ctrl_fsm
  import target_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        addrHit,
  input  logic        cfgSel,
  input  logic        userReady,
  input  logic        userRetry,
  input  cmd_class_e  liveClass,
  input  cmd_class_e  heldClass,
  output ctl_strobe_t ctl,
  output logic        devselN,
  output logic        trdyN,
  output logic        stopN
);

  typedef enum logic [3:0] {
    S_IDLE, S_SKIP, S_RD_TURN, S_RD_BURST, S_RD_ONE, S_WR_BURST,
    S_WR_ONE, S_CFG_TURN, S_CFG_RD, S_CFG_WR, S_RETRY, S_BACKOFF
  } state_e;

  state_e state, nextState;
  logic   claimOk, dataState, oneState, xfer;

  always_comb begin
    if (liveClass == CLS_CFG_RD || liveClass == CLS_CFG_WR) claimOk = cfgSel;
    else claimOk = (liveClass != CLS_NONE) && addrHit;
  end

  assign oneState  = (state == S_RD_ONE) || (state == S_WR_ONE) ||
                     (state == S_CFG_RD) || (state == S_CFG_WR);
  assign dataState = oneState || (state == S_RD_BURST) || (state == S_WR_BURST);
  assign xfer      = dataState && userReady && !irdyN;

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE: if (!frameN) begin
        if (!claimOk)       nextState = S_SKIP;
        else if (userRetry) nextState = S_RETRY;
        else case (liveClass)
          CLS_MEM_RD, CLS_IO_RD: nextState = S_RD_TURN;
          CLS_MEM_WR:            nextState = S_WR_BURST;
          CLS_IO_WR:             nextState = S_WR_ONE;
          CLS_CFG_RD:            nextState = S_CFG_TURN;
          default:               nextState = S_CFG_WR;
        endcase
      end
      S_SKIP:     if (frameN && irdyN) nextState = S_IDLE;
      S_RD_TURN:  nextState = (heldClass == CLS_IO_RD) ? S_RD_ONE : S_RD_BURST;
      S_CFG_TURN: nextState = S_CFG_RD;
      S_RD_BURST, S_WR_BURST: if (xfer && frameN) nextState = S_IDLE;
      S_RD_ONE, S_WR_ONE, S_CFG_RD, S_CFG_WR:
        if (xfer) nextState = frameN ? S_IDLE : S_RETRY;
      S_RETRY:    if (frameN) nextState = S_BACKOFF;
      default:    nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign devselN = (state == S_IDLE) || (state == S_SKIP) || (state == S_BACKOFF);
  assign trdyN   = !(dataState && userReady);
  assign stopN   = !(oneState || (state == S_RETRY));

  assign ctl.latchCmd = (state == S_IDLE) && !frameN;
  assign ctl.xfer     = xfer;
  assign ctl.driveAd  = (state == S_RD_BURST) || (state == S_RD_ONE) || (state == S_CFG_RD);

endmodule

// File: rtl/target_ctrl.sv
module target_ctrl
  import target_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [CMD_W-1:0] cbe,
  input  logic             addrHit,
  input  logic             cfgSel,
  input  logic             userReady,
  input  logic             userRetry,
  output logic             devselN,
  output logic             trdyN,
  output logic             stopN,
  output logic             adOe,
  output logic             parOe,
  output logic             memRdStb,
  output logic             memWrStb,
  output logic             ioRdStb,
  output logic             ioWrStb,
  output logic             cfgRdStb,
  output logic             cfgWrStb
);

  ctl_strobe_t         ctl;
  cmd_class_e          liveClass, heldClass;
  logic [NUM_CLS-1:0]  accessStb;

  target_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .addrHit(addrHit), .cfgSel(cfgSel), .userReady(userReady),
    .userRetry(userRetry), .liveClass(liveClass), .heldClass(heldClass),
    .ctl(ctl), .devselN(devselN), .trdyN(trdyN), .stopN(stopN)
  );

  target_ctrl_dp u_dp (
    .clk(clk), .rstN(rstN), .cbe(cbe), .ctl(ctl),
    .liveClass(liveClass), .heldClass(heldClass),
    .adOe(adOe), .parOe(parOe), .accessStb(accessStb)
  );

  assign memRdStb = accessStb[0];
  assign memWrStb = accessStb[1];
  assign ioRdStb  = accessStb[2];
  assign ioWrStb  = accessStb[3];
  assign cfgRdStb = accessStb[4];
  assign cfgWrStb = accessStb[5];

endmodule

// File: rtl/target_ctrl_chk.sv
module target_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic frameN,
  input logic irdyN,
  input logic devselN,
  input logic trdyN,
  input logic stopN,
  input logic adOe,
  input logic parOe,
  input logic memRdStb,
  input logic memWrStb,
  input logic ioRdStb,
  input logic ioWrStb,
  input logic cfgRdStb,
  input logic cfgWrStb
);

  logic [5:0] stbVec;
  assign stbVec = {cfgWrStb, cfgRdStb, ioWrStb, ioRdStb, memWrStb, memRdStb};

  assert_claim_needs_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> $past(!frameN));

  assert_ad_after_turn_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adOe) |-> $past(!devselN && trdyN));

  assert_ready_needs_devsel_R5: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);

  assert_strobe_needs_handshake_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stbVec != 6'd0) |-> (!irdyN && !trdyN));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbVec));

  assert_stop_needs_devsel_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |-> !devselN);

  assert_par_trails_ad_R9: assert property (@(posedge clk) disable iff (!rstN)
    parOe == $past(adOe));

endmodule

bind target_ctrl target_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
  .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .adOe(adOe), .parOe(parOe),
  .memRdStb(memRdStb), .memWrStb(memWrStb), .ioRdStb(ioRdStb),
  .ioWrStb(ioWrStb), .cfgRdStb(cfgRdStb), .cfgWrStb(cfgWrStb)
);

// File: tb/target_ctrl_tb.sv
module target_ctrl_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, frameN, irdyN, addrHit, cfgSel, userReady, userRetry;
  logic [3:0] cbe;
  logic devselN, trdyN, stopN, adOe, parOe;
  logic memRdStb, memWrStb, ioRdStb, ioWrStb, cfgRdStb, cfgWrStb;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic prevAd = 1'b0;

  target_ctrl u_dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbe(cbe),
    .addrHit(addrHit), .cfgSel(cfgSel), .userReady(userReady), .userRetry(userRetry),
    .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .adOe(adOe), .parOe(parOe),
    .memRdStb(memRdStb), .memWrStb(memWrStb), .ioRdStb(ioRdStb),
    .ioWrStb(ioWrStb), .cfgRdStb(cfgRdStb), .cfgWrStb(cfgWrStb)
  );

  // Access kind from the R2 code table: 1 memRd, 2 memWr, 3 ioRd, 4 ioWr, 5 cfgRd, 6 cfgWr.
  function automatic int kindOf(input logic [3:0] c);
    case (c)
      4'b0110, 4'b1100, 4'b1110: return 1;
      4'b0111, 4'b1111:          return 2;
      4'b0010:                   return 3;
      4'b0011:                   return 4;
      4'b1010:                   return 5;
      4'b1011:                   return 6;
      default:                   return 0;
    endcase
  endfunction

  // Inputs are already driven; sample 1 ns later, then move to the next negedge.
  // Expected parOe is the expected adOe of the previous clock (R9).
  task automatic look(input string req, input logic eDev, input logic eTrdy,
                      input logic eStop, input logic eAd, input logic [5:0] eStb);
    logic [10:0] act, exp;
    #1;
    act = {devselN, trdyN, stopN, adOe, parOe,
           cfgWrStb, cfgRdStb, ioWrStb, ioRdStb, memWrStb, memRdStb};
    exp = {eDev, eTrdy, eStop, eAd, prevAd, eStb};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s dev/trdy/stop/ad/par/stb actual=%b expected=%b", req, act, exp);
    end
    prevAd = eAd;
    @(negedge clk);
  endtask

  task automatic txn(input logic [3:0] cmd, input bit hit, input bit sel,
                     input bit retry, input int nData);
    int  k       = kindOf(cmd);
    bit  isCfg   = (k >= 5);
    bit  claimed = (k != 0) && (isCfg ? sel : hit);
    bit  rd      = (k == 1) || (k == 3) || (k == 5);
    bit  one     = (k >= 3);
    int  remain  = nData;
    bit  first   = 1'b1;
    bit  done    = 1'b0;
    // address clock
    frameN = 1'b0; irdyN = 1'b1; cbe = cmd; addrHit = hit; cfgSel = sel;
    userRetry = retry; userReady = 1'($urandom);
    look("R2", 1, 1, 1, 0, 6'd0);
    userRetry = 1'($urandom);
    cfgSel    = 1'($urandom);
    if (!claimed) begin
      for (int i = 0; i < 3; i++) begin
        irdyN = 1'b0; frameN = (i == 2); cbe = 4'($urandom); addrHit = 1'($urandom);
        look("R2", 1, 1, 1, 0, 6'd0);
      end
      frameN = 1'b1; irdyN = 1'b1;
      look("R2", 1, 1, 1, 0, 6'd0);
      return;
    end
    if (retry) begin
      irdyN = 1'b0; frameN = 1'b0;
      look("R8", 0, 1, 0, 0, 6'd0);
      frameN = 1'b1;
      look("R8", 0, 1, 0, 0, 6'd0);
      irdyN = 1'b1;
      look("R8", 1, 1, 1, 0, 6'd0);
      look("R8", 1, 1, 1, 0, 6'd0);
      return;
    end
    if (rd) begin
      irdyN = 1'b0; frameN = (nData == 1); cbe = 4'($urandom); userReady = 1'($urandom);
      look("R3", 0, 1, 1, 0, 6'd0);
    end
    while (!done) begin
      bit rdy = ($urandom % 4) != 0;
      bit xf;
      logic [5:0] eStb;
      if (remain == 1) begin irdyN = 1'b0; frameN = 1'b1; end
      else begin irdyN = (($urandom % 4) == 0); frameN = 1'b0; end
      userReady = rdy; cbe = 4'($urandom); addrHit = 1'($urandom);
      xf   = rdy && !irdyN;
      eStb = xf ? (6'd1 << (k - 1)) : 6'd0;
      look((!rd && first) ? "R4" : "R5", 0, !rdy, !one, rd, eStb);
      first = 1'b0;
      if (xf) begin
        remain--;
        if (one) begin
          if (!frameN) begin
            frameN = 1'b1; irdyN = 1'b0;
            look("R7", 0, 1, 0, 0, 6'd0);
            irdyN = 1'b1;
            look("R7", 1, 1, 1, 0, 6'd0);
          end
          done = 1'b1;
        end else if (remain == 0) done = 1'b1;
      end
    end
    frameN = 1'b1; irdyN = 1'b1;
    look(rd ? "R9" : "R6", 1, 1, 1, 0, 6'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; cbe = 4'd0; addrHit = 1'b0;
    cfgSel = 1'b0; userReady = 1'b0; userRetry = 1'b0;
    repeat (3) @(negedge clk);
    look("R1", 1, 1, 1, 0, 6'd0);
    rstN = 1'b1;
    look("R1", 1, 1, 1, 0, 6'd0);

    txn(4'b0000, 1, 1, 0, 2);  // R2 no-op never claimed
    txn(4'b1100, 1, 0, 0, 4);  // R6 burst read
    txn(4'b0010, 1, 0, 0, 1);  // R3 single I/O read
    txn(4'b0011, 1, 0, 0, 3);  // R7 disconnect after one write
    txn(4'b1010, 0, 1, 0, 1);  // R2 config read uses select
    txn(4'b1011, 1, 0, 0, 1);  // R2 config write without select
    txn(4'b0111, 1, 0, 1, 2);  // R8 retry on write
    txn(4'b0110, 1, 0, 1, 2);  // R8 retry on read
    txn(4'b0110, 0, 1, 0, 2);  // R2 memory miss
    txn(4'b1111, 1, 0, 0, 5);  // R4 burst write

    for (int t = 0; t < 300; t++) begin
      txn(4'($urandom), ($urandom % 4) != 0, 1'($urandom),
          ($urandom % 6) == 0, 1 + int'($urandom % 5));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule